// File: doc/BRIEF.md
# Controller Port Register Interface

This block sits between a CPU bus and two serial game-controller ports. A CPU write stores its low three data bits in output latches. Bit 0 of those latches is the load line that both controllers share: while it is high, the controllers capture their buttons in parallel. A CPU read of either port address returns an assembled byte. The read also holds that port's clock line low for as long as the read strobe stays high. When the strobe drops, the line returns high, and that rising edge tells the controller to shift out its next bit. The other port's clock stays high throughout.

The controller data lines are active low and pulled up, so the block inverts them. A button that is held reads as 1, and a port with nothing attached reads as 0. Bit 0 of the byte is the primary data line and bit 1 is the expansion data line. Bit 2 is the microphone level on the first port and an undriven bit on the second. The undriven bits take their value from a register that keeps the last byte seen on the data bus. That byte comes from a CPU write, from a read of this block, or from a snooped transfer such as the high byte of the port address.

Sequencing is a two-state machine. ST_IDLE keeps every port clock high. The START transition moves to ST_CLK_LOW when a read is requested and no write arrives in the same cycle. At START the block captures the read byte and the selected port, and it drives that port's clock low. The RELEASE transition returns to ST_IDLE in the first cycle in which the read request is low. This gives one clock pulse per access, however long the request is held.

Top module: `padport_regs`

## Requirements
- R1: After reset, ctl_out is 0, every bit of port_clk is 1 and cpu_rdata is 0x00.
- R2: In the cycle after a clock edge with cpu_wr high, ctl_out equals cpu_wdata[2:0]. Without cpu_wr, ctl_out keeps its value. ctl_out[0] is the shared controller load line.
- R3: In ST_IDLE, an edge with cpu_rd high and cpu_wr low (START) drives port_clk[cpu_port] low in the next cycle, with all other port_clk bits high. Without that condition, every port_clk bit stays high, and at most one bit is ever low.
- R4: While cpu_rd stays high in ST_CLK_LOW, port_clk holds its value even if cpu_port changes. The first edge with cpu_rd low (RELEASE) returns all bits to 1, so one access makes exactly one pulse.
- R5: At START, cpu_rdata[0] becomes the inverse of pri_line_n[cpu_port] and cpu_rdata[1] becomes the inverse of exp_line_n[cpu_port]. A port whose lines are both high reads 0 in both bits.
- R6: At START, cpu_rdata[2] becomes mic_in for port 0. For port 1 it becomes bit 2 of the last-bus-byte register.
- R7: At START, cpu_rdata[7:3] becomes bits 7:3 of the last-bus-byte register.
- R8: The last-bus-byte register, reset to 0x00, takes cpu_wdata on a write edge. Otherwise it takes the read byte on a START edge, or otherwise snoop_data when snoop_vld is high.
- R9: A cycle with cpu_wr and cpu_rd both high performs the write and starts no read. If cpu_rd stays high, the read starts in the next cycle.
- R10: cpu_rdata changes only at START edges. It holds through ST_CLK_LOW and ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Write strobe for the latch register |
| cpu_rd | input | 1 | Read request, level; may stay high for several cycles |
| cpu_port | input | 1 | Port selected for a read (0 or 1) |
| cpu_wdata | input | 8 | Write data |
| snoop_vld | input | 1 | Another bus transfer is visible this cycle |
| snoop_data | input | 8 | Byte of that other transfer |
| pri_line_n | input | 2 | Primary serial data line per port, active low |
| exp_line_n | input | 2 | Expansion serial data line per port, active low |
| mic_in | input | 1 | Microphone level for port 0 |
| cpu_rdata | output | 8 | Byte captured by the last read start |
| ctl_out | output | 3 | Latched write bits; bit 0 is the controller load line |
| port_clk | output | 2 | Per-port controller clock, idle high |

## Verification
A wrong state register shows at port_clk in the next cycle: the line stays low after the request drops, falls without a request, or pulses again during a held read. A wrong captured port index or a missed RELEASE also shows there within one cycle. A fault in the last-bus-byte register shows only on a later read. It appears in cpu_rdata[7:3], or in bit 2 for the second port, one cycle after the next START. For that reason the reference model tracks the register through every write, read and snoop, and the bench compares all output fields in every cycle.

// File: rtl/padport_pkg.sv
package padport_pkg;

    // Read sequencer states
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_CLK_LOW = 1'b1
    } seq_state_e;

    // Number of byte bits driven by the port logic (primary, expansion, mic)
    localparam int DRIVEN_BITS = 3;

endpackage

// File: rtl/padport_fsm.sv
module padport_fsm
    import padport_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int SEL_W     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic                 wr_req,
    input  logic [SEL_W-1:0]     sel,
    output logic                 start,
    output logic [NUM_PORTS-1:0] port_clk
);

    seq_state_e       state_q, state_d;
    logic [SEL_W-1:0] act_q;

    assign start = (state_q == ST_IDLE) && rd_req && !wr_req;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)   state_d = ST_CLK_LOW;
            ST_CLK_LOW: if (!rd_req) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) act_q <= sel;
        end
    end

    // outputs
    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            port_clk[i] = !((state_q == ST_CLK_LOW) && (act_q == SEL_W'(i)));
        end
    end

endmodule

// File: rtl/padport_byte.sv
module padport_byte
    import padport_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int SEL_W     = 1,
    parameter int DATA_W    = 8,
    parameter int MIC_PORT  = 0
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic [NUM_PORTS-1:0] pri_line_n,
    input  logic [NUM_PORTS-1:0] exp_line_n,
    input  logic                 mic_in,
    input  logic [DATA_W-1:0]    bus_last,
    output logic [DATA_W-1:0]    rd_byte
);

    always_comb begin
        rd_byte                         = bus_last;
        rd_byte[0]                      = ~pri_line_n[sel];
        rd_byte[1]                      = ~exp_line_n[sel];
        rd_byte[DRIVEN_BITS-1]          = (sel == SEL_W'(MIC_PORT)) ? mic_in
                                                                    : bus_last[DRIVEN_BITS-1];
    end

endmodule

// File: rtl/padport_hold.sv
module padport_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              start,
    input  logic [DATA_W-1:0] rd_byte,
    input  logic              snoop_vld,
    input  logic [DATA_W-1:0] snoop_data,
    output logic [DATA_W-1:0] bus_last,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_last <= '0;
            rdata    <= '0;
        end else begin
            if (wr)             bus_last <= wdata;
            else if (start)     bus_last <= rd_byte;
            else if (snoop_vld) bus_last <= snoop_data;
            if (start)          rdata    <= rd_byte;
        end
    end

endmodule

// File: rtl/padport_regs.sv
module padport_regs
    import padport_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 8,
    parameter int CTL_W     = 3,
    parameter int MIC_PORT  = 0,
    localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_wr,
    input  logic                 cpu_rd,
    input  logic [SEL_W-1:0]     cpu_port,
    input  logic [DATA_W-1:0]    cpu_wdata,
    input  logic                 snoop_vld,
    input  logic [DATA_W-1:0]    snoop_data,
    input  logic [NUM_PORTS-1:0] pri_line_n,
    input  logic [NUM_PORTS-1:0] exp_line_n,
    input  logic                 mic_in,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic [CTL_W-1:0]     ctl_out,
    output logic [NUM_PORTS-1:0] port_clk
);

    localparam logic [NUM_PORTS-1:0] CLK_IDLE = '1;

    logic              start;
    logic [DATA_W-1:0] bus_last;
    logic [DATA_W-1:0] rd_byte;

    padport_fsm #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (cpu_rd),
        .wr_req   (cpu_wr),
        .sel      (cpu_port),
        .start    (start),
        .port_clk (port_clk)
    );

    padport_byte #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W), .DATA_W(DATA_W),
                   .MIC_PORT(MIC_PORT)) u_byte (
        .sel        (cpu_port),
        .pri_line_n (pri_line_n),
        .exp_line_n (exp_line_n),
        .mic_in     (mic_in),
        .bus_last   (bus_last),
        .rd_byte    (rd_byte)
    );

    padport_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cpu_wr),
        .wdata      (cpu_wdata),
        .start      (start),
        .rd_byte    (rd_byte),
        .snoop_vld  (snoop_vld),
        .snoop_data (snoop_data),
        .bus_last   (bus_last),
        .rdata      (cpu_rdata)
    );

    // output latches
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_out <= '0;
        else if (cpu_wr) ctl_out <= cpu_wdata[CTL_W-1:0];
    end

    // R2
    ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> ctl_out == $past(cpu_wdata[CTL_W-1:0]));
    // R2
    ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(ctl_out));
    // R3
    clk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~port_clk));
    // R3
    clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_clk == CLK_IDLE && !cpu_rd) |=> port_clk == CLK_IDLE);
    // R9
    clk_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_clk == CLK_IDLE && cpu_wr) |=> port_clk == CLK_IDLE);
    // R4
    clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_clk != CLK_IDLE && cpu_rd) |=> $stable(port_clk));
    // R4
    clk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_clk != CLK_IDLE && !cpu_rd) |=> port_clk == CLK_IDLE);
    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_clk != CLK_IDLE) |=> $stable(cpu_rdata));

endmodule

// File: tb/padport_regs_tb.sv
`timescale 1ns/1ps
module padport_regs_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_port = 1'b0;
    logic [7:0] cpu_wdata = '0, snoop_data = '0;
    logic       snoop_vld = 1'b0;
    logic [1:0] pri_line_n = 2'b11, exp_line_n = 2'b11;
    logic       mic_in = 1'b0;
    logic [7:0] cpu_rdata;
    logic [2:0] ctl_out;
    logic [1:0] port_clk;

    int checks = 0;
    int errors = 0;

    // reference state
    logic       m_low = 1'b0, m_port = 1'b0;
    logic [2:0] m_ctl = '0;
    logic [7:0] m_hold = '0, m_rdata = '0;

    always #2 clk = ~clk;

    padport_regs u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_port(cpu_port), .cpu_wdata(cpu_wdata), .snoop_vld(snoop_vld),
        .snoop_data(snoop_data), .pri_line_n(pri_line_n), .exp_line_n(exp_line_n),
        .mic_in(mic_in), .cpu_rdata(cpu_rdata), .ctl_out(ctl_out), .port_clk(port_clk)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_clk();
        if (!m_low) return 2'b11;
        return m_port ? 2'b01 : 2'b10;
    endfunction

    task automatic model_check();
        chk("R2 ctl_out", {5'b0, ctl_out}, {5'b0, m_ctl});
        chk("R3 R4 R9 port_clk", {6'b0, port_clk}, {6'b0, exp_clk()});
        chk("R5 data bits", {6'b0, cpu_rdata[1:0]}, {6'b0, m_rdata[1:0]});
        chk("R6 bit2", {7'b0, cpu_rdata[2]}, {7'b0, m_rdata[2]});
        chk("R7 R8 R10 upper bits", {3'b0, cpu_rdata[7:3]}, {3'b0, m_rdata[7:3]});
    endtask

    // drive one cycle from a negedge, update the model, check at the next negedge
    task automatic cyc(input logic wr, input logic [7:0] wd, input logic rd, input logic pt,
                       input logic sv, input logic [7:0] sd, input logic [1:0] pn,
                       input logic [1:0] en, input logic mic);
        logic       start;
        logic [7:0] byte_v;
        cpu_wr = wr; cpu_wdata = wd; cpu_rd = rd; cpu_port = pt;
        snoop_vld = sv; snoop_data = sd; pri_line_n = pn; exp_line_n = en; mic_in = mic;
        start  = !m_low && rd && !wr;
        byte_v = {m_hold[7:3], (pt == 1'b0) ? mic : m_hold[2], ~en[pt], ~pn[pt]};
        if (wr) m_ctl = wd[2:0];
        if (wr)         m_hold = wd;
        else if (start) m_hold = byte_v;
        else if (sv)    m_hold = sd;
        if (start) begin
            m_rdata = byte_v; m_low = 1'b1; m_port = pt;
        end else if (m_low && !rd) begin
            m_low = 1'b0;
        end
        @(negedge clk);
        model_check();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 0, 8'h00, 2'b11, 2'b11, 0);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ctl_out reset", {5'b0, ctl_out}, 8'h00);
        chk("R1 port_clk reset", {6'b0, port_clk}, 8'h03);
        chk("R1 cpu_rdata reset", cpu_rdata, 8'h00);
        rst_n = 1'b1;
        idle(2);

        // R2 strobe 1 then 0
        cyc(1, 8'h01, 0, 0, 0, 8'h00, 2'b11, 2'b11, 0);
        chk("R2 load line high", {5'b0, ctl_out}, 8'h01);
        cyc(1, 8'h00, 0, 0, 0, 8'h00, 2'b11, 2'b11, 0);
        chk("R2 load line low", {5'b0, ctl_out}, 8'h00);

        // R7 snoop address high byte, then read port 0 with a pressed primary line
        cyc(0, 8'h00, 0, 0, 1, 8'h40, 2'b11, 2'b11, 0);
        cyc(0, 8'h00, 1, 0, 0, 8'h00, 2'b10, 2'b11, 1);
        chk("R3 port0 clock low", {6'b0, port_clk}, 8'h02);
        chk("R5 R6 R7 port0 byte", cpu_rdata, 8'h45);
        // R4 held request: one pulse, port select ignored
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 1, 1, 0, 8'h00, 2'b01, 2'b00, 0);
        chk("R4 held low", {6'b0, port_clk}, 8'h02);
        chk("R10 rdata held", cpu_rdata, 8'h45);
        cyc(0, 8'h00, 0, 0, 0, 8'h00, 2'b11, 2'b11, 0);
        chk("R4 released", {6'b0, port_clk}, 8'h03);

        // R5 R6 empty port 1 reads 0, no mic on port 1
        cyc(0, 8'h00, 0, 0, 1, 8'h41, 2'b11, 2'b11, 1);
        cyc(0, 8'h00, 1, 1, 0, 8'h00, 2'b11, 2'b11, 1);
        chk("R5 R6 empty port1 byte", cpu_rdata, 8'h40);
        chk("R3 port1 clock low", {6'b0, port_clk}, 8'h01);
        idle(1);

        // R9 write and read together
        cyc(1, 8'h06, 1, 0, 0, 8'h00, 2'b11, 2'b11, 0);
        chk("R9 no pulse on write", {6'b0, port_clk}, 8'h03);
        chk("R9 write done", {5'b0, ctl_out}, 8'h06);
        cyc(0, 8'h00, 1, 0, 0, 8'h00, 2'b11, 2'b11, 0);
        chk("R9 deferred start", {6'b0, port_clk}, 8'h02);
        chk("R8 write fills upper bits", cpu_rdata, 8'h00);
        idle(1);

        // R8 read wins over snoop
        cyc(0, 8'h00, 1, 1, 1, 8'hF8, 2'b10, 2'b11, 0);
        idle(1);
        cyc(0, 8'h00, 1, 1, 0, 8'h00, 2'b11, 2'b11, 0);
        chk("R8 read over snoop", cpu_rdata, 8'h00);
        idle(1);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic wr, rd, sv;
            wr = ($urandom % 8) == 0;
            rd = ($urandom % 2) == 0;
            sv = ($urandom % 3) == 0;
            cyc(wr, 8'($urandom), rd, 1'($urandom), sv, 8'($urandom),
                2'($urandom), 2'($urandom), 1'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule